// File: doc/BRIEF.md
# Binary Clock Timer with Tick Interrupts

This block divides a 32.768 kHz base clock through a single binary counter. The eight slowest stages of that counter, running at 128 Hz down to 1 Hz, can be read as two 4-bit data nibbles. Three of the stages, at 32 Hz, 8 Hz and 2 Hz, each raise a sticky event flag when they fall. A flag drives the interrupt request only while its enable bit is set.

Software controls the block through a small register port that runs in the same clock domain as the counter. A run bit starts and stops the counter. Writing the run bit to 0 stops the counter and also clears it, including the hidden prescaler below the 128 Hz stage. The event flags clear themselves when software reads them, so a single read both reports the pending events and acknowledges them.

Top module: `tick_timer`

## Requirements
- R1: After reset, all eight addresses read 0 and `irq` is low.
- R2: Stage timing:
  - While the run bit is 1, the counter advances by one on every clock edge.
  - Address 0 returns the 128, 64, 32 and 16 Hz stages in bits 0, 1, 2 and 3.
  - Address 1 returns the 8, 4, 2 and 1 Hz stages in bits 0, 1, 2 and 3.
  - A stage at rate f has a period of 32768/f clocks. It reads 0 for the first half of the period and 1 for the second half, counted from the last clear.
  - The counter wraps to zero after 32768 clocks.
- R3: A write to the control register with bit 0 clear resets every stage, including the prescaler, to zero at that edge. The stages stay at zero until the run bit is set again.
- R4: Addresses 0 and 1 are read-only; writes to them have no effect. Addresses 4 to 7 read 0 and ignore writes.
- R5: Event flags:
  - Each flag is set at the clock edge on which its stage falls from 1 to 0, whatever the state of its enable bit.
  - The flags read at address 3: bit 0 is 32 Hz, bit 1 is 8 Hz, bit 2 is 2 Hz, and bit 3 reads 0.
- R6: A read of address 3 returns the flags and clears them at that edge. If a stage falls on the same edge as the read, its flag is set afterwards.
- R7: The control register is at address 2. Bit 0 is run, bit 1 enables the 32 Hz interrupt, bit 2 enables 8 Hz and bit 3 enables 2 Hz. All four bits read back as written.
- R8: `irq` is high exactly when at least one flag is set and its enable bit is 1. It follows the flags and enable bits with no extra delay.
- R9: A stage that is forced to zero by a run-bit clear does not set its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz base clock, also used by the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, required for flag clear-on-read |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- The address, strobes and write data are known at every clock edge once reset has been released.
- Each cycle carries at most one meaningful access.

The assertions therefore treat a control write that clears the run bit as the only event that can zero the counter outside reset. The bench keeps to these assumptions. It drives every bus input from tasks on the falling clock edge, never leaves an input undriven, and issues one read or one write per cycle.

The random phase mixes control writes, writes to read-only and unmapped addresses, and reads at arbitrary counter phases. The directed cases cover the following:
- a read that falls on the same edge as a flag being set;
- a stop issued while a stage is high;
- the full 1 Hz wrap.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // register nibble width and number of tapped stages
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned TAP_N  = 8;

  // interrupt sources: stage index counted from the 128 Hz stage
  localparam int unsigned NSRC = 3;
  localparam int unsigned SRC_TAP [NSRC] = '{2, 4, 6};

  // control register bit holding the run flag
  localparam int unsigned CTRL_RUN = 0;

  typedef enum logic [1:0] {
    SEL_TAP_LO = 2'd0,
    SEL_TAP_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_FLAG   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/tt_divider.sv
module tt_divider
  import tick_timer_pkg::*;
#(
  parameter int unsigned PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  output logic [TAP_N-1:0] taps,
  output logic [NSRC-1:0]  fall
);

  localparam int unsigned CNT_W = PRE_W + TAP_N;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
  end

  assign taps = cnt_q[PRE_W +: TAP_N];

  // A stage falls when every bit at and below it is 1 and the counter steps.
  for (genvar k = 0; k < NSRC; k++) begin : g_fall
    localparam int unsigned HI = PRE_W + SRC_TAP[k];
    assign fall[k] = run & ~clr & (&cnt_q[HI:0]);

    a_r5_fall_drops_stage: assert property (@(posedge clk) disable iff (!rst_n)
      fall[k] |=> !taps[SRC_TAP[k]]);
  end

  a_r3_clear_zeroes_taps: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (taps == '0));

  a_r2_advance_when_run: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/tt_flags.sv
module tt_flags
  import tick_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic            rd_clr,
  output logic [NSRC-1:0] flag
);

  logic [NSRC-1:0] flag_q;

  // set has priority over the read-clear so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~{NSRC{rd_clr}}) | set;
  end

  assign flag = flag_q;

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (set == '0)) |=> (flag == '0));

  a_r6_set_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> (|flag));

endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [NIB_W-1:0]  wdata,
  input  logic [TAP_N-1:0]  taps,
  input  logic [NSRC-1:0]   flags,
  output logic              run,
  output logic [NSRC-1:0]   mask,
  output logic              clr,
  output logic              rd_clr,
  output logic [NIB_W-1:0]  rdata
);

  logic            mapped;
  reg_sel_e        sel;
  logic            ctrl_wr;
  logic            run_q;
  logic [NSRC-1:0] mask_q;

  assign mapped  = ((addr >> 2) == '0);
  assign sel     = reg_sel_e'(addr[1:0]);
  assign ctrl_wr = wr & mapped & (sel == SEL_CTRL);
  assign clr     = ctrl_wr & ~wdata[CTRL_RUN];
  assign rd_clr  = rd & mapped & (sel == SEL_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mask_q <= '0;
    end else if (ctrl_wr) begin
      run_q  <= wdata[CTRL_RUN];
      mask_q <= wdata[1 +: NSRC];
    end
  end

  assign run  = run_q;
  assign mask = mask_q;

  always_comb begin
    rdata = '0;
    if (mapped) begin
      unique case (sel)
        SEL_TAP_LO: rdata = taps[0 +: NIB_W];
        SEL_TAP_HI: rdata = taps[NIB_W +: NIB_W];
        SEL_CTRL:   rdata = NIB_W'({mask_q, run_q});
        SEL_FLAG:   rdata = NIB_W'(flags);
        default:    rdata = '0;
      endcase
    end
  end

  a_r7_ctrl_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ({mask, run} == $past(wdata)));

  a_r7_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> ($stable(run) && $stable(mask)));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned PRE_W  = 7,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_wdata,
  output logic [3:0]        bus_rdata,
  output logic              irq
);

  logic [TAP_N-1:0] taps;
  logic [NSRC-1:0]  fall;
  logic [NSRC-1:0]  flags;
  logic [NSRC-1:0]  mask;
  logic             run;
  logic             clr;
  logic             rd_clr;

  tt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wdata  (bus_wdata),
    .taps   (taps),
    .flags  (flags),
    .run    (run),
    .mask   (mask),
    .clr    (clr),
    .rd_clr (rd_clr),
    .rdata  (bus_rdata)
  );

  tt_divider #(.PRE_W(PRE_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clr   (clr),
    .taps  (taps),
    .fall  (fall)
  );

  tt_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (fall),
    .rd_clr (rd_clr),
    .flag   (flags)
  );

  assign irq = |(flags & mask);

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  a_r9_stop_sets_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (flags == '0)) |=> (flags == '0));

endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // model state
  int unsigned m_cnt  = 0;
  bit          m_run  = 0;
  bit [2:0]    m_mask = 0;
  bit [2:0]    m_flag = 0;

  always #2.5 clk = ~clk;

  tick_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  function automatic int unsigned src_shift(int k);
    // stage index 2, 4, 6 above the 128 Hz bit (bit 7)
    return 7 + 2 * (k + 1);
  endfunction

  function automatic logic [3:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return 4'((m_cnt >> 7) & 15);
      3'd1: return 4'((m_cnt >> 11) & 15);
      3'd2: return {m_mask, m_run};
      3'd3: return {1'b0, m_flag};
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(m_flag & m_mask);
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(bit wr, bit rd, logic [2:0] a, logic [3:0] d);
    int unsigned nx = m_cnt;
    bit [2:0] setv = '0;
    bit clr = wr && (a == 3'd2) && !d[0];
    if (clr) nx = 0;
    else if (m_run) begin
      for (int k = 0; k < 3; k++) begin
        int unsigned per = 32'd1 << (src_shift(k) + 1);
        if ((m_cnt % per) == per - 1) setv[k] = 1'b1;
      end
      nx = (m_cnt + 1) & 32'h7FFF;
    end
    if (rd && a == 3'd3) m_flag = '0;
    m_flag |= setv;
    if (wr && a == 3'd2) begin
      m_run  = d[0];
      m_mask = d[3:1];
    end
    m_cnt = nx;
  endtask

  // one bus cycle, starting and ending just after a falling edge
  task automatic cyc(bit wr, bit rd, logic [2:0] a, logic [3:0] d, string req);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    if (rd) chk(req, bus_rdata, exp_read(a));
    @(posedge clk);
    model_edge(wr, rd, a, d);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, 4'd0, "");
  endtask

  task automatic rd_chk(logic [2:0] a, string req);
    cyc(0, 1, a, 4'd0, req);
  endtask

  task automatic irq_chk(string req);
    #1;
    chk(req, {3'b0, irq}, {3'b0, exp_irq()});
  endtask

  string rtag [8] = '{"R2", "R2", "R7", "R6", "R4", "R4", "R4", "R4"};

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired before the end of stimulus");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h5EED_0042);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state on every address
    for (int a = 0; a < 8; a++) rd_chk(3'(a), "R1");
    irq_chk("R1");

    // R4: writes to read-only and unmapped addresses do nothing
    cyc(1, 0, 3'd0, 4'hF, "");
    cyc(1, 0, 3'd1, 4'hF, "");
    cyc(1, 0, 3'd5, 4'hF, "");
    rd_chk(3'd0, "R4"); rd_chk(3'd1, "R4"); rd_chk(3'd5, "R4"); rd_chk(3'd2, "R4");

    // R2/R5: run with interrupts disabled until the 32 Hz stage falls
    cyc(1, 0, 3'd2, 4'b0001, "");
    idle(600);
    rd_chk(3'd0, "R2");
    idle(500);
    rd_chk(3'd3, "R5");
    irq_chk("R8");

    // R8: enabling the 32 Hz source raises irq on a pending flag
    idle(1100);
    cyc(1, 0, 3'd2, 4'b0011, "");
    rd_chk(3'd2, "R7");
    irq_chk("R8");
    rd_chk(3'd3, "R6");
    rd_chk(3'd3, "R6");
    irq_chk("R8");

    // R6: a read on the same edge as a 32 Hz fall keeps the flag
    while ((m_cnt % 1024) != 1023) idle(1);
    rd_chk(3'd3, "R6");
    rd_chk(3'd3, "R6");

    // R2: run to just before the full wrap and across it
    cyc(1, 0, 3'd2, 4'b1111, "");
    while (m_cnt != 32767) idle(1);
    rd_chk(3'd0, "R2");
    rd_chk(3'd1, "R2");
    rd_chk(3'd3, "R5");
    irq_chk("R8");
    rd_chk(3'd3, "R6");

    // R9/R3: stop while the 32 Hz stage is high
    while ((m_cnt % 1024) != 700) idle(1);
    rd_chk(3'd3, "R9");
    cyc(1, 0, 3'd2, 4'b1110, "");
    rd_chk(3'd3, "R9");
    rd_chk(3'd0, "R3");
    idle(2000);
    rd_chk(3'd0, "R3");
    rd_chk(3'd1, "R3");
    cyc(1, 0, 3'd2, 4'b1111, "");
    idle(300);
    rd_chk(3'd0, "R3");

    // constrained random phase
    for (int it = 0; it < 70; it++) begin
      int unsigned op = $urandom % 8;
      logic [2:0] a = 3'($urandom % 8);
      idle(int'($urandom % 1500));
      if (op < 4) rd_chk(a, rtag[a]);
      else if (op < 6) cyc(1, 0, 3'd2, 4'($urandom % 16) | 4'b0001, "");
      else if (op == 6) cyc(1, 0, 3'd2, 4'($urandom % 16), "");
      else cyc(1, 0, a, 4'($urandom % 16), "");
      irq_chk("R8");
      rd_chk(3'd2, "R7");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule